// File: doc/BRIEF.md
# Two-Way Intersection Signal Sequencer with Crossing Requests

This block drives the red, yellow and green lamps of two opposing traffic directions, A and B. It cycles green, yellow, then over to the other direction, while the direction that is not moving stays red. A pedestrian pushbutton at any of four corners can end the current green early, but only after that green has run a minimum time. All three intervals are cycle counts held in parameters. With the defaults and a 1 kHz clock they give 30 s green, 5 s yellow and a 15 s minimum green. A test build can shrink them.

The control is a Moore state machine. It talks to a small datapath through a strobe struct. The datapath holds one shared interval counter, three compare taps on that counter, and two sticky request flags. Each lamp phase starts with a one-cycle transition state. That state shows the new lamps, restarts the counter and, on entry to a green, clears the request flags. The compare taps are set two counts below each interval, so the transition cycle plus the counted cycles add up to exactly the parameter value.

Top module: `xlight_top`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `lampA` shows green and `lampB` shows red, and no crossing request is pending.
- R2: Each lamp bus is one-hot with bit 0 = green, bit 1 = yellow, bit 2 = red. Exactly one bit is set on every cycle.
- R3: Whenever one direction is not red, the other direction is red.
- R4: Without pending requests, each green lasts exactly `GREEN_CYC` cycles, except the first green after reset, which lasts `GREEN_CYC`-1. Greens alternate A, B, A, B.
- R5: Every yellow lasts exactly `YELLOW_CYC` cycles. It always follows that direction's green, and the other direction's green follows it.
- R6: A request on corner bit 0 or 1 is latched as a flag that can end only A's green. A request on corner bit 2 or 3 is latched as a flag that can end only B's green. A flag stays set until the next start of a green.
- R7: When a request is sampled at clock edge k, its flag is visible from the next cycle. The green of its direction ends after the first cycle, from then on, in which that green has been shown for at least `SHORT_CYC` cycles, counting the current cycle.
- R8: On the first cycle of every green, both flags are cleared. A request present only in that cycle is discarded.
- R9: Every green lasts at least `SHORT_CYC` and at most `GREEN_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (1 kHz for the default intervals) |
| rstN | input | 1 | Asynchronous active-low reset |
| cornerReq | input | 4 | Crossing pushbuttons; bits 1:0 stop A, bits 3:2 stop B |
| lampA | output | 3 | Direction A lamps {red, yellow, green} |
| lampB | output | 3 | Direction B lamps {red, yellow, green} |

## Verification
Suppose the state register, counter or a request flag holds a wrong value. It shows at the lamp buses as a green or yellow that is too long or too short, or as a lamp code that is not one-hot. At the latest it shows when the current phase should have ended, which is within one green plus one yellow. The bench compares both lamp buses every cycle against a phase-and-elapsed-time model. It also measures each green and yellow length at the ports. So an off-by-one in a compare tap, a lost clear, or a flag routed to the wrong direction fails at the first phase boundary it affects.

// File: rtl/xlight_pkg.sv
package xlight_pkg;

  typedef enum logic [2:0] {
    ST_A_GO,
    ST_TO_A_YEL,
    ST_A_YEL,
    ST_TO_B_GO,
    ST_B_GO,
    ST_TO_B_YEL,
    ST_B_YEL,
    ST_TO_A_GO
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClear;
    logic flagClear;
  } dpCtrl_t;

  // datapath -> control conditions
  typedef struct packed {
    logic greenDone;
    logic yellowDone;
    logic pastShort;
    logic wantStopA;
    logic wantStopB;
  } dpStat_t;

  localparam logic [2:0] LAMP_GREEN  = 3'b001;
  localparam logic [2:0] LAMP_YELLOW = 3'b010;
  localparam logic [2:0] LAMP_RED    = 3'b100;

endpackage

// File: rtl/xlight_datapath.sv
module xlight_datapath
  import xlight_pkg::*;
#(
  parameter int GREEN_CYC  = 30000,
  parameter int YELLOW_CYC = 5000,
  parameter int SHORT_CYC  = 15000,
  parameter int CNT_W      = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] cornerReq,
  input  dpCtrl_t    ctrl,
  output dpStat_t    stat
);

  // one transition cycle plus counts 0..TERM make the full interval
  localparam logic [CNT_W-1:0] GREEN_TERM  = CNT_W'(GREEN_CYC - 2);
  localparam logic [CNT_W-1:0] YELLOW_TERM = CNT_W'(YELLOW_CYC - 2);
  localparam logic [CNT_W-1:0] SHORT_TERM  = CNT_W'(SHORT_CYC - 2);
  localparam logic [CNT_W-1:0] CNT_MAX     = {CNT_W{1'b1}};
  localparam int NUM_DIR = 2;

  logic [CNT_W-1:0]   elapsed;
  logic [NUM_DIR-1:0] stopFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              elapsed <= '0;
    else if (ctrl.cntClear) elapsed <= '0;
    else if (elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               stopFlag[d] <= 1'b0;
      else if (ctrl.flagClear) stopFlag[d] <= 1'b0;
      else if (|cornerReq[2*d+1 -: 2]) stopFlag[d] <= 1'b1;
    end

    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (stopFlag[d] && !ctrl.flagClear) |=> stopFlag[d]);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.flagClear |=> !stopFlag[d]);
  end

  always_comb begin
    stat.greenDone  = (elapsed == GREEN_TERM);
    stat.yellowDone = (elapsed == YELLOW_TERM);
    stat.pastShort  = (elapsed >= SHORT_TERM);
    stat.wantStopA  = stopFlag[0];
    stat.wantStopB  = stopFlag[1];
  end

  p_count_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cntClear |=> (elapsed == '0));

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    elapsed <= GREEN_TERM + 1'b1);

endmodule

// File: rtl/xlight_control.sv
module xlight_control
  import xlight_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStat_t    stat,
  output dpCtrl_t    ctrl,
  output logic [2:0] lampA,
  output logic [2:0] lampB
);

  phase_t state, nextState;
  logic   leaveA, leaveB;

  assign leaveA = stat.greenDone | (stat.pastShort & stat.wantStopA);
  assign leaveB = stat.greenDone | (stat.pastShort & stat.wantStopB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_A_GO;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_A_GO:     if (leaveA) nextState = ST_TO_A_YEL;
      ST_TO_A_YEL: nextState = ST_A_YEL;
      ST_A_YEL:    if (stat.yellowDone) nextState = ST_TO_B_GO;
      ST_TO_B_GO:  nextState = ST_B_GO;
      ST_B_GO:     if (leaveB) nextState = ST_TO_B_YEL;
      ST_TO_B_YEL: nextState = ST_B_YEL;
      ST_B_YEL:    if (stat.yellowDone) nextState = ST_TO_A_GO;
      ST_TO_A_GO:  nextState = ST_A_GO;
      default:     nextState = ST_A_GO;
    endcase
  end

  always_comb begin
    ctrl.cntClear  = (state == ST_TO_A_YEL) || (state == ST_TO_B_GO) ||
                     (state == ST_TO_B_YEL) || (state == ST_TO_A_GO);
    ctrl.flagClear = (state == ST_TO_B_GO) || (state == ST_TO_A_GO);
  end

  always_comb begin
    unique case (state)
      ST_A_GO, ST_TO_A_GO:   begin lampA = LAMP_GREEN;  lampB = LAMP_RED;    end
      ST_TO_A_YEL, ST_A_YEL: begin lampA = LAMP_YELLOW; lampB = LAMP_RED;    end
      ST_TO_B_GO, ST_B_GO:   begin lampA = LAMP_RED;    lampB = LAMP_GREEN;  end
      ST_TO_B_YEL, ST_B_YEL: begin lampA = LAMP_RED;    lampB = LAMP_YELLOW; end
      default:               begin lampA = LAMP_RED;    lampB = LAMP_RED;    end
    endcase
  end

  p_lamp_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(lampA) == 1) && ($countones(lampB) == 1));

  p_other_red_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lampA != LAMP_RED) |-> (lampB == LAMP_RED));

  p_green_to_yellow_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lampA[0]) |-> (lampA == LAMP_YELLOW));

  p_yellow_to_other_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lampA[1]) |-> (lampB == LAMP_GREEN));

endmodule

// File: rtl/xlight_top.sv
module xlight_top
  import xlight_pkg::*;
#(
  parameter int GREEN_CYC  = 30000,
  parameter int YELLOW_CYC = 5000,
  parameter int SHORT_CYC  = 15000,
  parameter int CNT_W      = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] cornerReq,
  output logic [2:0] lampA,
  output logic [2:0] lampB
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  xlight_datapath #(
    .GREEN_CYC (GREEN_CYC),
    .YELLOW_CYC(YELLOW_CYC),
    .SHORT_CYC (SHORT_CYC),
    .CNT_W     (CNT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cornerReq(cornerReq),
    .ctrl     (ctrl),
    .stat     (stat)
  );

  xlight_control u_control (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .ctrl (ctrl),
    .lampA(lampA),
    .lampB(lampB)
  );

endmodule

// File: tb/xlight_top_bench.sv
module xlight_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int GREEN  = 40;
  localparam int YEL    = 6;
  localparam int SHORT  = 20;
  localparam int RUN_CYC = 3000;
  localparam logic [2:0] G = 3'b001, Y = 3'b010, RD = 3'b100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] cornerReq = '0;
  logic [2:0] lampA, lampB;

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  int phase = 0;      // 0 A green, 1 A yellow, 2 B green, 3 B yellow
  int el = 2;         // cycles shown in phase, current included
  bit [1:0] flags = '0;
  int greenIdx = 0;

  // port-side run measurement
  int runA = 0, runB = 0, yrunA = 0, yrunB = 0, doneGreens = 0;
  int expLen[5];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlight_top #(.GREEN_CYC(GREEN), .YELLOW_CYC(YEL), .SHORT_CYC(SHORT), .CNT_W(8))
    u_xlight_top (.clk(clk), .rstN(rstN), .cornerReq(cornerReq), .lampA(lampA), .lampB(lampB));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] expLamps(input int p);
    case (p)
      0: return {G, RD};
      1: return {Y, RD};
      2: return {RD, G};
      default: return {RD, Y};
    endcase
  endfunction

  function automatic logic [3:0] directedReq(input int gi, input int p, input int e);
    if (p == 2 && gi == 1 && e == 3) return 4'b0001;          // R6: A corner during B green
    if (p == 0 && gi == 2 && e == 1) return 4'b0010;          // R8: first green cycle
    if (p == 2 && gi == 3 && e == 4) return 4'b1000;          // R7: early request
    if (p == 0 && gi == 4 && e == SHORT + 3) return 4'b0001;  // R7: late request
    return 4'b0000;
  endfunction

  task automatic modelStep(input logic [3:0] req);
    bit leave;
    if (phase % 2 == 0) leave = (el == GREEN) || (el >= SHORT && flags[phase/2]);
    else                leave = (el == YEL);
    if (phase % 2 == 0 && el == 1) flags = '0;
    else flags = flags | {|req[3:2], |req[1:0]};
    if (leave) begin
      phase = (phase + 1) % 4;
      el = 1;
      if (phase % 2 == 0) greenIdx++;
    end else el++;
  endtask

  task automatic lengthMonitor();
    int len;
    if (lampA == G || lampB == G) begin
      if (lampA == G) runA++; else runB++;
    end
    if (lampA != G && runA > 0) begin len = runA; runA = 0; greenEnded(len); end
    if (lampB != G && runB > 0) begin len = runB; runB = 0; greenEnded(len); end
    if (lampA == Y) yrunA++;
    else if (yrunA > 0) begin check(yrunA == YEL, "R5 yellow A length", yrunA, YEL); yrunA = 0; end
    if (lampB == Y) yrunB++;
    else if (yrunB > 0) begin check(yrunB == YEL, "R5 yellow B length", yrunB, YEL); yrunB = 0; end
  endtask

  task automatic greenEnded(input int len);
    check(len >= SHORT && len <= GREEN, "R9 green length bound", len, SHORT);
    if (doneGreens < 5) begin
      case (doneGreens)
        0: check(len == expLen[0], "R4 first green after reset", len, expLen[0]);
        1: check(len == expLen[1], "R6 other corner does not shorten", len, expLen[1]);
        2: check(len == expLen[2], "R8 first-cycle request dropped", len, expLen[2]);
        3: check(len == expLen[3], "R7 early request ends at minimum", len, expLen[3]);
        default: check(len == expLen[4], "R7 late request ends next cycle", len, expLen[4]);
      endcase
    end
    doneGreens++;
  endtask

  initial begin
    logic [3:0] req;
    logic [5:0] want;
    string tag;
    expLen[0] = GREEN - 1;
    expLen[1] = GREEN;
    expLen[2] = GREEN;
    expLen[3] = SHORT;
    expLen[4] = SHORT + 4;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check({lampA, lampB} == {G, RD}, "R1 lamps in reset", {lampA, lampB}, {G, RD});
    rstN = 1'b1;
    for (int n = 0; n < RUN_CYC; n++) begin
      want = expLamps(phase);
      if (n == 0) tag = "R1 first cycle after reset";
      else if (phase % 2 == 0 && flags != 0) tag = "R7 lamps with pending request";
      else if (phase % 2 == 1) tag = "R5 yellow lamps";
      else tag = "R4 green lamps";
      check({lampA, lampB} == want, tag, {lampA, lampB}, want);
      check($countones(lampA) == 1 && $countones(lampB) == 1, "R2 one-hot lamps", {lampA, lampB}, want);
      check(lampA == RD || lampB == RD, "R3 one side red", {lampA, lampB}, want);
      lengthMonitor();
      if (greenIdx < 5) req = directedReq(greenIdx, phase, el);
      else begin
        req = '0;
        for (int b = 0; b < 4; b++) req[b] = (($urandom % 48) == 0);
      end
      cornerReq = req;
      @(posedge clk);
      #1;
      modelStep(req);
    end
    check(doneGreens >= 5, "R4 directed greens completed", doneGreens, 5);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule